// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Engine

This block is one memory-to-stream DMA channel. It walks a chain of descriptors kept in a word-addressed memory. For each descriptor it does the following in order:

- fetches the header words;
- refuses any descriptor that software has not handed back;
- on a start-of-frame descriptor, sends the application words on a sideband stream;
- moves the payload out on a ready/valid data stream, in bounded chunks that pass through a small local buffer;
- writes a completion status back into the descriptor;
- follows the next pointer.

The channel always works in tail-pointer mode. Software programs the current pointer and sets the run bit. Writing the tail pointer then starts the walk. The walk ends, with the idle flag set, once the descriptor at the tail has been handled. A fetched descriptor whose status already shows completion stops the channel with the halted flag set. Each completed end-of-frame descriptor produces a one-cycle completion pulse.

A descriptor occupies consecutive words from its base address:

| Word | Contents |
|------|----------|
| +0 | next pointer |
| +1 | buffer address |
| +2 | control word |
| +3 | status word |
| +4 onward | the application words |

All addresses and lengths count 32-bit words.

The walker state machine has eight states, each named in the code:

| State | What it does |
|-------|--------------|
| S_STOP | Waits for a start. |
| S_DESC | Reads the four header words. |
| S_APP_RD | Reads one application word. |
| S_APP_TX | Sends that word on the sideband stream. |
| S_LOAD | Reads payload words into the chunk buffer. |
| S_SEND | Streams the buffered chunk. |
| S_WB | Writes the completion status. |
| S_ADV | Moves the current pointer to the next descriptor. |

Its transitions are:

- S_STOP to S_DESC on a pending tail write while running, not halted and not idle.
- S_DESC to S_STOP when the status word shows completion.
- S_DESC to S_APP_RD on start of frame.
- S_DESC to S_LOAD or S_WB otherwise.
- S_APP_RD to S_APP_TX on acknowledge.
- S_APP_TX to S_APP_RD while application words remain.
- S_APP_TX to S_LOAD or S_WB after the last application word.
- S_LOAD to S_SEND when the chunk is full or the payload is exhausted.
- S_SEND to S_LOAD or S_WB when the chunk is drained.
- S_WB to S_ADV on acknowledge.
- S_ADV to S_STOP at the tail or when run is clear.
- S_ADV to S_DESC otherwise.
- Any state to S_STOP on a channel reset.

Top module: `sgtx_engine`

## Requirements
- R1: After reset the control register reads 0x2 (run bit 0 clear, tail-mode bit 1 always set), the status register reads 0x1 (halted bit 0 set, idle bit 1 clear), the current pointer reads 0, and no memory request, data beat or sideband beat is presented.
- R2: Writing the tail register (address 3) while running starts a fetch of the descriptor at the current pointer (address 2): four reads at offsets +0, +1, +2, +3 in that order.
- R3: A fetched descriptor whose status word has bit 31 set makes the channel set halted and stop. It sends no beat, writes nothing back and leaves the current pointer unchanged.
- R4: When control bit 27 (start of frame) is set, the APP_WORDS words at offsets +4 and up are sent in order on the sideband stream before any payload beat, with the sideband last flag on the final word only.
- R5: The payload is the number of words given by control bits [22:0], read from consecutive addresses starting at the buffer address. It is sent in order on the data stream, and lengths longer than CHUNK_WORDS are moved as several buffered chunks.
- R6: The data last flag is asserted only on the final payload word, and only when control bit 26 (end of frame) is set.
- R7: After the payload, the value 0x8000_0000 is written to offset +3. An end-of-frame descriptor then raises done_pulse for exactly one cycle, one cycle after that write is acknowledged. A descriptor without end of frame raises no pulse.
- R8: After write-back the current pointer takes the next pointer. If the handled descriptor was the tail, status bit 1 (idle) is set and no further memory request is issued.
- R9: A tail write while run is clear, or while halted, starts nothing.
- R10: A control write (address 0) with bit 0 set and bit 2 clear clears halted and idle. A control write with bit 2 set clears run, sets halted and aborts any transfer at once.
- R11: A memory request holds its address and direction until acknowledged. Data and sideband beats hold their contents until accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register select: 0 control, 1 status, 2 current, 3 tail |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read select |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| app_valid | output | 1 | Sideband word valid |
| app_data | output | 32 | Sideband application word |
| app_last | output | 1 | Final sideband word |
| app_ready | input | 1 | Sideband sink ready |
| tx_valid | output | 1 | Payload beat valid |
| tx_data | output | 32 | Payload word |
| tx_last | output | 1 | End-of-frame beat |
| tx_ready | input | 1 | Payload sink ready |
| done_pulse | output | 1 | One-cycle completion of an end-of-frame descriptor |

## Verification
A walker that loses its place in the descriptor header or in the chunk counters shows within the same descriptor. The effect is an out-of-order address on the memory port, a payload word out of sequence, or a last flag on the wrong beat, and the scoreboard catches each of these on the beat where it happens. A wrong flag decision shows at the register port as soon as the walk ends. Examples are a start while halted, a missed tail match, or a halted flag left set after a run write. Such a fault appears as a status value other than 0x1 or 0x2, a current pointer off by one descriptor, or memory traffic after idle. A dropped or doubled completion pulse shows in the pulse count taken after each chain.

// File: rtl/sgtx_pkg.sv
package sgtx_pkg;

    // register select codes
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_CUR  = 2'd2;
    localparam logic [1:0] REG_TAIL = 2'd3;

    // control and status bit positions
    localparam int CTL_RUN   = 0;
    localparam int CTL_TMODE = 1;
    localparam int CTL_RESET = 2;
    localparam int ST_HALT   = 0;
    localparam int ST_IDLE   = 1;

    // descriptor control / status fields
    localparam int LEN_W   = 23;
    localparam int DC_EOF  = 26;
    localparam int DC_SOF  = 27;
    localparam int DS_DONE = 31;

    // descriptor word offsets
    localparam int OFF_NEXT = 0;
    localparam int OFF_BUF  = 1;
    localparam int OFF_CTRL = 2;
    localparam int OFF_STAT = 3;
    localparam int OFF_APP  = 4;
    localparam int DESC_HDR_WORDS = 4;

    localparam logic [31:0] WB_VALUE = 32'h8000_0000;

    typedef enum logic [2:0] {
        S_STOP,
        S_DESC,
        S_APP_RD,
        S_APP_TX,
        S_LOAD,
        S_SEND,
        S_WB,
        S_ADV
    } walk_state_t;

endpackage

// File: rtl/sgtx_regs.sv
module sgtx_regs
    import sgtx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [1:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic          set_halted,
    input  logic          set_idle,
    input  logic          cur_load,
    input  logic [AW-1:0] cur_next,
    output logic          run,
    output logic          halted,
    output logic          idle,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] tail_ptr,
    output logic          tail_wr,
    output logic          chan_rst
);

    localparam int PAD = 32 - AW;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data[31:AW];

    assign tail_wr  = wr_en && (wr_addr == REG_TAIL);
    assign chan_rst = wr_en && (wr_addr == REG_CTRL) && wr_data[CTL_RESET];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            halted   <= 1'b1;
            idle     <= 1'b0;
            cur_ptr  <= '0;
            tail_ptr <= '0;
        end else begin
            if (set_halted) halted <= 1'b1;
            if (set_idle)   idle   <= 1'b1;
            if (cur_load)   cur_ptr <= cur_next;
            if (wr_en) begin
                unique case (wr_addr)
                    REG_CTRL: begin
                        if (wr_data[CTL_RESET]) begin
                            run    <= 1'b0;
                            halted <= 1'b1;
                            idle   <= 1'b0;
                        end else begin
                            run <= wr_data[CTL_RUN];
                            if (wr_data[CTL_RUN]) begin
                                halted <= 1'b0;
                                idle   <= 1'b0;
                            end
                        end
                    end
                    REG_STAT: ;
                    REG_CUR: begin
                        if (!cur_load) cur_ptr <= wr_data[AW-1:0];
                    end
                    REG_TAIL: begin
                        tail_ptr <= wr_data[AW-1:0];
                        idle     <= 1'b0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL: begin
                rd_data[CTL_RUN]   = run;
                rd_data[CTL_TMODE] = 1'b1;
            end
            REG_STAT: begin
                rd_data[ST_HALT] = halted;
                rd_data[ST_IDLE] = idle;
            end
            REG_CUR:  rd_data = {{PAD{1'b0}}, cur_ptr};
            REG_TAIL: rd_data = {{PAD{1'b0}}, tail_ptr};
        endcase
    end

    // R10: a channel reset write leaves the channel stopped and halted
    p_rst_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (halted && !run));

endmodule

// File: rtl/sgtx_chunk_buf.sv
module sgtx_chunk_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [DEPTH*W-1:0] flat;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IW'(i))) q <= wr_data;
        end
        assign flat[i*W +: W] = q;
    end

    assign rd_data = flat[rd_idx*W +: W];

endmodule

// File: rtl/sgtx_walker.sv
module sgtx_walker
    import sgtx_pkg::*;
#(
    parameter int AW          = 16,
    parameter int APP_WORDS   = 5,
    parameter int CHUNK_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          kick,
    input  logic          run,
    input  logic          halted,
    input  logic          idle,
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] tail_ptr,
    output logic          set_halted,
    output logic          set_idle,
    output logic          cur_load,
    output logic [AW-1:0] cur_next,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          app_valid,
    output logic [31:0]   app_data,
    output logic          app_last,
    input  logic          app_ready,
    output logic          tx_valid,
    output logic [31:0]   tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          done
);

    localparam int IDX_MAX = (APP_WORDS > DESC_HDR_WORDS) ? APP_WORDS : DESC_HDR_WORDS;
    localparam int IDXW    = $clog2(IDX_MAX);
    localparam int CW      = $clog2(CHUNK_WORDS + 1);
    localparam int CIW     = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;
    localparam logic [IDXW-1:0] HDR_LAST  = IDXW'(DESC_HDR_WORDS - 1);
    localparam logic [IDXW-1:0] APP_LAST  = IDXW'(APP_WORDS - 1);
    localparam logic [CW-1:0]   FILL_FULL = CW'(CHUNK_WORDS - 1);

    walk_state_t state, state_d;

    logic [IDXW-1:0]  idx;
    logic [AW-1:0]    d_next;
    logic [AW-1:0]    rd_addr;
    logic [LEN_W-1:0] remain;
    logic             d_sof, d_eof;
    logic [31:0]      app_hold;
    logic [CW-1:0]    fill, send_idx;
    logic             kick_q, done_q;
    logic [31:0]      buf_rd;

    logic mem_done, tx_fire, app_fire, chunk_end, start_ok, at_tail;

    assign mem_done  = mem_req && mem_ack;
    assign tx_fire   = tx_valid && tx_ready;
    assign app_fire  = app_valid && app_ready;
    assign chunk_end = (send_idx + CW'(1)) == fill;
    assign start_ok  = kick_q && run && !halted && !idle;
    assign at_tail   = (cur_ptr == tail_ptr);

    sgtx_chunk_buf #(.DEPTH(CHUNK_WORDS), .W(32)) u_buf (
        .clk     (clk),
        .wr_en   ((state == S_LOAD) && mem_done),
        .wr_idx  (fill[CIW-1:0]),
        .wr_data (mem_rdata),
        .rd_idx  (send_idx[CIW-1:0]),
        .rd_data (buf_rd)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            S_STOP:   if (start_ok) state_d = S_DESC;
            S_DESC: begin
                if (mem_done && idx == HDR_LAST) begin
                    if (mem_rdata[DS_DONE])             state_d = S_STOP;
                    else if (d_sof && APP_WORDS > 0)    state_d = S_APP_RD;
                    else if (remain == '0)              state_d = S_WB;
                    else                                state_d = S_LOAD;
                end
            end
            S_APP_RD: if (mem_done) state_d = S_APP_TX;
            S_APP_TX: begin
                if (app_fire) begin
                    if (idx != APP_LAST)   state_d = S_APP_RD;
                    else if (remain == '0) state_d = S_WB;
                    else                   state_d = S_LOAD;
                end
            end
            S_LOAD: begin
                if (mem_done && (fill == FILL_FULL || remain == LEN_W'(1)))
                    state_d = S_SEND;
            end
            S_SEND: begin
                if (tx_fire && chunk_end)
                    state_d = (remain == '0) ? S_WB : S_LOAD;
            end
            S_WB:     if (mem_done) state_d = S_ADV;
            S_ADV:    state_d = (at_tail || !run) ? S_STOP : S_DESC;
        endcase
        if (abort) state_d = S_STOP;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_STOP;
        else        state <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            d_next   <= '0;
            rd_addr  <= '0;
            remain   <= '0;
            d_sof    <= 1'b0;
            d_eof    <= 1'b0;
            app_hold <= '0;
            fill     <= '0;
            send_idx <= '0;
            kick_q   <= 1'b0;
            done_q   <= 1'b0;
        end else if (abort) begin
            idx      <= '0;
            fill     <= '0;
            send_idx <= '0;
            kick_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (kick)                 kick_q <= 1'b1;
            else if (state == S_STOP) kick_q <= 1'b0;
            unique case (state)
                S_STOP: idx <= '0;
                S_DESC: begin
                    if (mem_done) begin
                        case (idx)
                            IDXW'(OFF_NEXT): d_next  <= mem_rdata[AW-1:0];
                            IDXW'(OFF_BUF):  rd_addr <= mem_rdata[AW-1:0];
                            IDXW'(OFF_CTRL): begin
                                remain <= mem_rdata[LEN_W-1:0];
                                d_sof  <= mem_rdata[DC_SOF];
                                d_eof  <= mem_rdata[DC_EOF];
                            end
                            default: ;
                        endcase
                        idx <= (idx == HDR_LAST) ? '0 : idx + IDXW'(1);
                    end
                end
                S_APP_RD: if (mem_done) app_hold <= mem_rdata;
                S_APP_TX: begin
                    if (app_fire) idx <= (idx == APP_LAST) ? '0 : idx + IDXW'(1);
                end
                S_LOAD: begin
                    if (mem_done) begin
                        fill    <= fill + CW'(1);
                        rd_addr <= rd_addr + AW'(1);
                        remain  <= remain - LEN_W'(1);
                    end
                end
                S_SEND: begin
                    if (tx_fire) begin
                        if (chunk_end) begin
                            send_idx <= '0;
                            fill     <= '0;
                        end else begin
                            send_idx <= send_idx + CW'(1);
                        end
                    end
                end
                S_WB:  if (mem_done && d_eof) done_q <= 1'b1;
                S_ADV: idx <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        app_valid  = 1'b0;
        tx_valid   = 1'b0;
        set_halted = 1'b0;
        set_idle   = 1'b0;
        cur_load   = 1'b0;
        unique case (state)
            S_STOP: ;
            S_DESC: begin
                mem_req    = 1'b1;
                mem_addr   = cur_ptr + AW'(idx);
                set_halted = mem_done && (idx == HDR_LAST) && mem_rdata[DS_DONE];
            end
            S_APP_RD: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr + AW'(OFF_APP) + AW'(idx);
            end
            S_APP_TX: app_valid = 1'b1;
            S_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = rd_addr;
            end
            S_SEND: tx_valid = 1'b1;
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur_ptr + AW'(OFF_STAT);
                mem_wdata = WB_VALUE;
            end
            S_ADV: begin
                cur_load = 1'b1;
                set_idle = at_tail;
            end
        endcase
    end

    assign cur_next = d_next;
    assign app_data = app_hold;
    assign app_last = (state == S_APP_TX) && (idx == APP_LAST);
    assign tx_data  = buf_rd;
    assign tx_last  = (state == S_SEND) && d_eof && (remain == '0) && chunk_end;
    assign done     = done_q;

    // R11: a pending memory request keeps address and direction
    p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11: a stalled payload beat keeps its contents
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !abort) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4: a stalled sideband word keeps its contents
    p_app_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (app_valid && !app_ready && !abort) |=> (app_valid && $stable(app_data) && $stable(app_last)));

    // R7: the completion pulse lasts one cycle
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sgtx_engine.sv
module sgtx_engine
    import sgtx_pkg::*;
#(
    parameter int AW          = 16,
    parameter int APP_WORDS   = 5,
    parameter int CHUNK_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_wr_addr,
    input  logic [31:0]   reg_wr_data,
    input  logic [1:0]    reg_rd_addr,
    output logic [31:0]   reg_rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          app_valid,
    output logic [31:0]   app_data,
    output logic          app_last,
    input  logic          app_ready,
    output logic          tx_valid,
    output logic [31:0]   tx_data,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          done_pulse
);

    logic          run, halted, idle, tail_wr, chan_rst;
    logic          set_halted, set_idle, cur_load;
    logic [AW-1:0] cur_ptr, tail_ptr, cur_next;

    sgtx_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .set_halted (set_halted),
        .set_idle   (set_idle),
        .cur_load   (cur_load),
        .cur_next   (cur_next),
        .run        (run),
        .halted     (halted),
        .idle       (idle),
        .cur_ptr    (cur_ptr),
        .tail_ptr   (tail_ptr),
        .tail_wr    (tail_wr),
        .chan_rst   (chan_rst)
    );

    sgtx_walker #(
        .AW          (AW),
        .APP_WORDS   (APP_WORDS),
        .CHUNK_WORDS (CHUNK_WORDS)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (chan_rst),
        .kick       (tail_wr),
        .run        (run),
        .halted     (halted),
        .idle       (idle),
        .cur_ptr    (cur_ptr),
        .tail_ptr   (tail_ptr),
        .set_halted (set_halted),
        .set_idle   (set_idle),
        .cur_load   (cur_load),
        .cur_next   (cur_next),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .app_valid  (app_valid),
        .app_data   (app_data),
        .app_last   (app_last),
        .app_ready  (app_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .done       (done_pulse)
    );

    // R3: a halted channel issues no memory traffic
    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_req);

    // R8: an idle channel issues no memory traffic
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mem_req);

endmodule

// File: tb/sgtx_engine_bench.sv
module sgtx_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 16;
    localparam int APPW  = 5;
    localparam int CHUNK = 4;

    logic          clk, rst_n;
    logic          reg_wr_en;
    logic [1:0]    reg_wr_addr, reg_rd_addr;
    logic [31:0]   reg_wr_data, reg_rd_data;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          app_valid, app_last, app_ready;
    logic [31:0]   app_data;
    logic          tx_valid, tx_last, tx_ready;
    logic [31:0]   tx_data;
    logic          done_pulse;

    sgtx_engine #(.AW(AW), .APP_WORDS(APPW), .CHUNK_WORDS(CHUNK)) u_sgtx_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .app_valid(app_valid), .app_data(app_data), .app_last(app_last), .app_ready(app_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .done_pulse(done_pulse)
    );

    logic [31:0]   mem [0:1023];
    logic [33:0]   exp_q[$];   // [33] sideband, [32] last, [31:0] word
    int            n_checks, n_fail;
    int            done_cnt, acc_cnt, wr_cnt, acc_n;
    logic [AW-1:0] acc_log [0:7];
    logic [AW-1:0] held_addr;
    bit            finished;

    task automatic chk(string req, string what, logic [33:0] act, logic [33:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // memory model with varying latency
    initial begin
        int lat, wcnt;
        lat = 0; wcnt = 0;
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (wcnt > 0) chk("R11", "address held while waiting", 34'(mem_addr), 34'(held_addr));
                held_addr = mem_addr;
                if (wcnt >= lat) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[9:0]] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = mem[mem_addr[9:0]];
                    end
                    if (acc_n < 8) acc_log[acc_n] = mem_addr;
                    acc_n++;
                    acc_cnt++;
                    wcnt = 0;
                    lat = (lat + 1) % 3;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // stream sinks and scoreboard monitor
    initial begin
        int ph;
        ph = 0; tx_ready = 1'b0; app_ready = 1'b0;
        forever begin
            @(negedge clk);
            ph++;
            tx_ready  = (ph % 5) != 2;
            app_ready = (ph % 3) != 0;
            #1;
            if (app_valid && app_ready) begin
                if (exp_q.size() == 0) chk("R4", "unexpected sideband word", {2'b11, app_data}, 34'h0);
                else chk("R4", "sideband word/order", {1'b1, app_last, app_data}, exp_q.pop_front());
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) chk("R5", "unexpected payload beat", {2'b01, tx_data}, 34'h0);
                else chk("R5/R6", "payload word/last/order", {1'b0, tx_last, tx_data}, exp_q.pop_front());
            end
            if (done_pulse) done_cnt++;
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd_addr = a;
        #2;
        v = reg_rd_data;
    endtask

    // driver: lays out a descriptor and pushes what it should produce
    task automatic put_desc(int base, int nxt, int bufa, int len, bit sof, bit eof,
                            logic [31:0] stat, bit expect_it);
        mem[base + 0] = 32'(nxt);
        mem[base + 1] = 32'(bufa);
        mem[base + 2] = (32'(sof) << 27) | (32'(eof) << 26) | 32'(len);
        mem[base + 3] = stat;
        for (int k = 0; k < APPW; k++) mem[base + 4 + k] = 32'hA500_0000 | 32'(base << 8) | 32'(k);
        for (int k = 0; k < len; k++) mem[bufa + k] = 32'h5A00_0000 | 32'(bufa << 8) | 32'(k);
        if (expect_it) begin
            if (sof) for (int k = 0; k < APPW; k++)
                exp_q.push_back({1'b1, k == APPW - 1, mem[base + 4 + k]});
            for (int k = 0; k < len; k++)
                exp_q.push_back({1'b0, eof && (k == len - 1), mem[bufa + k]});
        end
    endtask

    task automatic wait_stop();
        logic [31:0] s;
        int t;
        t = 0;
        do begin
            reg_read(2'd1, s);
            t++;
        end while (s[1:0] == 2'b00 && t < 3000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int d0, w0, a0;
        n_checks = 0; n_fail = 0; done_cnt = 0; acc_cnt = 0; wr_cnt = 0; acc_n = 0;
        finished = 0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0; reg_rd_addr = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); chk("R1", "control after reset", 34'(v), 34'h2);
        reg_read(2'd1, v); chk("R1", "status after reset", 34'(v), 34'h1);
        reg_read(2'd2, v); chk("R1", "current after reset", 34'(v), 34'h0);
        chk("R1", "quiet outputs", {31'b0, mem_req, tx_valid, app_valid}, 34'h0);

        // chain of three: SOF non-EOF, long EOF, SOF+EOF
        put_desc(32'h100, 32'h120, 32'h200, 3,  1, 0, 0, 1);
        put_desc(32'h120, 32'h140, 32'h240, 10, 0, 1, 0, 1);
        put_desc(32'h140, 32'h160, 32'h280, 5,  1, 1, 0, 1);
        reg_write(2'd2, 32'h100);
        reg_write(2'd0, 32'h1);
        reg_read(2'd1, v); chk("R10", "run write clears halted", 34'(v), 34'h0);
        acc_n = 0;
        reg_write(2'd3, 32'h140);
        wait_stop();
        for (int i = 0; i < 4; i++) chk("R2", "header fetch order", 34'(acc_log[i]), 34'(32'h100 + i));
        reg_read(2'd1, v); chk("R8", "idle after tail", 34'(v), 34'h2);
        reg_read(2'd2, v); chk("R8", "current advanced past tail", 34'(v), 34'h160);
        chk("R5", "all items delivered", 34'(exp_q.size()), 34'h0);
        chk("R7", "pulses only for EOF descriptors", 34'(done_cnt), 34'h2);
        chk("R7", "write-back A", 34'(mem[32'h103]), 34'h8000_0000);
        chk("R7", "write-back B", 34'(mem[32'h123]), 34'h8000_0000);
        chk("R7", "write-back C", 34'(mem[32'h143]), 34'h8000_0000);
        a0 = acc_cnt; repeat (10) @(negedge clk);
        chk("R8", "no traffic when idle", 34'(acc_cnt), 34'(a0));

        // already-completed descriptor halts the channel
        put_desc(32'h160, 32'h180, 32'h2C0, 2, 0, 1, 32'h8000_0000, 0);
        d0 = done_cnt; w0 = wr_cnt;
        reg_write(2'd3, 32'h160);
        wait_stop();
        reg_read(2'd1, v); chk("R3", "halted on completed descriptor", 34'(v), 34'h1);
        reg_read(2'd2, v); chk("R3", "current unchanged", 34'(v), 34'h160);
        chk("R3", "no write-back", 34'(wr_cnt), 34'(w0));
        chk("R3", "no pulse", 34'(done_cnt), 34'(d0));

        // channel reset, then a tail write with run clear
        reg_write(2'd0, 32'h4);
        reg_read(2'd0, v); chk("R10", "reset clears run", 34'(v), 34'h2);
        mem[32'h163] = '0;
        a0 = acc_cnt;
        reg_write(2'd3, 32'h180);
        repeat (30) @(negedge clk);
        chk("R9", "tail write with run clear starts nothing", 34'(acc_cnt), 34'(a0));
        reg_read(2'd1, v); chk("R9", "still halted", 34'(v), 34'h1);

        // exact-chunk non-EOF then one-word EOF
        reg_write(2'd0, 32'h1);
        reg_read(2'd1, v); chk("R10", "run write clears halted again", 34'(v), 34'h0);
        put_desc(32'h160, 32'h180, 32'h2C0, 4, 0, 0, 0, 1);
        put_desc(32'h180, 32'h1A0, 32'h300, 1, 0, 1, 0, 1);
        d0 = done_cnt;
        reg_write(2'd3, 32'h180);
        wait_stop();
        reg_read(2'd1, v); chk("R8", "idle after second chain", 34'(v), 34'h2);
        reg_read(2'd2, v); chk("R8", "current after second chain", 34'(v), 34'h1A0);
        chk("R6", "all items delivered", 34'(exp_q.size()), 34'h0);
        chk("R7", "one pulse", 34'(done_cnt), 34'(d0 + 1));
        chk("R7", "write-back non-EOF", 34'(mem[32'h163]), 34'h8000_0000);

        // zero-length SOF+EOF: sideband only, still completes
        put_desc(32'h1A0, 32'h1C0, 32'h340, 0, 1, 1, 0, 1);
        d0 = done_cnt;
        reg_write(2'd3, 32'h1A0);
        wait_stop();
        chk("R4", "sideband words delivered", 34'(exp_q.size()), 34'h0);
        chk("R7", "pulse for empty EOF", 34'(done_cnt), 34'(d0 + 1));

        // abort a long transfer with a channel reset
        put_desc(32'h1C0, 32'h1E0, 32'h380, 40, 0, 1, 0, 1);
        reg_write(2'd3, 32'h1C0);
        repeat (30) @(negedge clk);
        reg_write(2'd0, 32'h4);
        chk("R10", "abort silences outputs", {31'b0, mem_req, tx_valid, app_valid}, 34'h0);
        reg_read(2'd1, v); chk("R10", "halted after abort", 34'(v), 34'h1);
        exp_q.delete();
        a0 = acc_cnt; repeat (20) @(negedge clk);
        chk("R10", "no traffic after abort", 34'(acc_cnt), 34'(a0));

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule